// File: doc/BRIEF.md
# Multiplexed Latch Bus Exchanger

This block joins one 12-bit A port to two 12-bit B ports, bank 1 and bank 2, with a storage latch on each of the four paths. From A toward B, the A input feeds two latches, one per bank. Each latch has its own capture enable, so an A word can be stored in one bank or in both. Each bank output has its own active-low enable. From B toward A, each bank's input feeds its own latch. A select input chooses which of those two latches drives A, and A has its own active-low enable.

Each tri-state pin is split into three signals: data in, data out and an output-enable flag. The latches are level-sensitive in behaviour but are built from flip-flops. While a capture enable is high, the path output follows its input in the same cycle and the storage flop takes the input at every clock edge. While the enable is low, the path gives back the word taken at the last clock edge at which the enable was high. The control pins are plain levels. Every port takes a word in every cycle, so no port has a valid/ready handshake or back-pressure.

Top module: `mux_latch_exchanger`

## Requirements
- R1: While `rst` is high, all three output-enable flags are 0 and all data outputs are 0. A synchronous reset clears all four latches to zero.
- R2: While `ab_le1` (or `ab_le2`) is high and the bank's enable `oe_b1_n` (or `oe_b2_n`) is low, that bank's output equals `a_din` in the same cycle.
- R3: While an A-to-B capture enable is low, that bank's output keeps the `a_din` value sampled at the last rising clock edge at which the enable was high, or zero if there was no such edge since reset. Changes on `a_din` have no effect on it.
- R4: Each B-to-A latch (`ba_le1`, `ba_le2`) is transparent to its bank's data input while its enable is high. While the enable is low, the latch holds the value from the last clock edge at which the enable was high.
- R5: `a_src_bank1` = 1 routes the bank-1 B-to-A latch to `a_dout`, and `a_src_bank1` = 0 routes the bank-2 latch.
- R6: Output enables are active low and act independently of each other. A disabled port shows output-enable flag 0 and data out 0.
- R7: Both B banks can capture the same A word at once and can be driven at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_din | input | 12 | Data arriving on the A port |
| a_dout | output | 12 | Data driven onto the A port |
| a_oe | output | 1 | A port driver enabled |
| b1_din | input | 12 | Data arriving on bank-1 B port |
| b1_dout | output | 12 | Data driven onto bank-1 B port |
| b1_oe | output | 1 | Bank-1 driver enabled |
| b2_din | input | 12 | Data arriving on bank-2 B port |
| b2_dout | output | 12 | Data driven onto bank-2 B port |
| b2_oe | output | 1 | Bank-2 driver enabled |
| ab_le1 | input | 1 | A-to-bank-1 latch transparent when high |
| ab_le2 | input | 1 | A-to-bank-2 latch transparent when high |
| ba_le1 | input | 1 | Bank-1-to-A latch transparent when high |
| ba_le2 | input | 1 | Bank-2-to-A latch transparent when high |
| oe_a_n | input | 1 | A driver enable, active low |
| oe_b1_n | input | 1 | Bank-1 driver enable, active low |
| oe_b2_n | input | 1 | Bank-2 driver enable, active low |
| a_src_bank1 | input | 1 | 1 routes the bank-1 latch to A, 0 routes the bank-2 latch |

## Verification
The hardest situation to reach is a held bank whose value must survive several later cycles. In that time `a_din` keeps changing, the other bank is loaded, and the driver is switched on and off. The stimulus table loads bank 1 and then bank 2 with different words and then changes A with both enables low. Later rows enable each bank alone and then all ports together, so the held words are read long after their capture. A directed step then applies reset while the latches hold nonzero words and all enables are active. It checks that the outputs are forced off during reset and read back zero after reset.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int NBANK = 2;

  typedef enum logic {
    SRC_BANK2 = 1'b0,
    SRC_BANK1 = 1'b1
  } a_src_e;
endpackage

// File: rtl/xchg_latch.sv
module xchg_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)     held <= '0;
    else if (le) held <= d;
  end

  // Transparent view: follows d while open, held word while closed.
  always_comb begin
    if (rst)     q = '0;
    else if (le) q = d;
    else         q = held;
  end
endmodule

// File: rtl/xchg_drv.sv
module xchg_drv #(
  parameter int W = 12
) (
  input  logic         rst,
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic         oe,
  output logic [W-1:0] dout
);
  always_comb begin
    oe   = !rst && !en_n;
    dout = oe ? d : '0;
  end
endmodule

// File: rtl/xchg_amux.sv
module xchg_amux
  import xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  a_src_e       src,
  input  logic [W-1:0] bank1,
  input  logic [W-1:0] bank2,
  output logic [W-1:0] q
);
  always_comb begin
    unique case (src)
      SRC_BANK1: q = bank1;
      default:   q = bank2;
    endcase
  end
endmodule

// File: rtl/mux_latch_exchanger.sv
module mux_latch_exchanger
  import xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  input  logic [W-1:0] b1_din,
  output logic [W-1:0] b1_dout,
  output logic         b1_oe,
  input  logic [W-1:0] b2_din,
  output logic [W-1:0] b2_dout,
  output logic         b2_oe,
  input  logic         ab_le1,
  input  logic         ab_le2,
  input  logic         ba_le1,
  input  logic         ba_le2,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n,
  input  logic         a_src_bank1
);
  logic [W-1:0] b_din   [NBANK];
  logic [W-1:0] b_dout  [NBANK];
  logic         b_oe    [NBANK];
  logic         ab_le   [NBANK];
  logic         ba_le   [NBANK];
  logic         b_en_n  [NBANK];
  logic [W-1:0] ab_q    [NBANK];
  logic [W-1:0] ba_q    [NBANK];
  logic [W-1:0] a_sel_q;

  always_comb begin
    b_din[0]  = b1_din;   b_din[1]  = b2_din;
    ab_le[0]  = ab_le1;   ab_le[1]  = ab_le2;
    ba_le[0]  = ba_le1;   ba_le[1]  = ba_le2;
    b_en_n[0] = oe_b1_n;  b_en_n[1] = oe_b2_n;
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    xchg_latch #(.W(W)) u_ab (
      .clk(clk), .rst(rst), .le(ab_le[k]), .d(a_din), .q(ab_q[k])
    );
    xchg_latch #(.W(W)) u_ba (
      .clk(clk), .rst(rst), .le(ba_le[k]), .d(b_din[k]), .q(ba_q[k])
    );
    xchg_drv #(.W(W)) u_drv (
      .rst(rst), .en_n(b_en_n[k]), .d(ab_q[k]), .oe(b_oe[k]), .dout(b_dout[k])
    );
  end

  xchg_amux #(.W(W)) u_amux (
    .src(a_src_e'(a_src_bank1)), .bank1(ba_q[0]), .bank2(ba_q[1]), .q(a_sel_q)
  );

  xchg_drv #(.W(W)) u_adrv (
    .rst(rst), .en_n(oe_a_n), .d(a_sel_q), .oe(a_oe), .dout(a_dout)
  );

  assign b1_dout = b_dout[0];
  assign b2_dout = b_dout[1];
  assign b1_oe   = b_oe[0];
  assign b2_oe   = b_oe[1];
endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_din,
  input logic [W-1:0] a_dout,
  input logic         a_oe,
  input logic [W-1:0] b1_din,
  input logic [W-1:0] b1_dout,
  input logic         b1_oe,
  input logic [W-1:0] b2_din,
  input logic [W-1:0] b2_dout,
  input logic         b2_oe,
  input logic         ab_le1,
  input logic         ab_le2,
  input logic         ba_le1,
  input logic         ba_le2,
  input logic         oe_a_n,
  input logic         oe_b1_n,
  input logic         oe_b2_n,
  input logic         a_src_bank1
);
  always @(posedge clk) begin
    if (rst === 1'b1) begin
      assert_reset_quiet_R1: assert (!a_oe && !b1_oe && !b2_oe);
    end
  end

  assert_b1_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (ab_le1 && !oe_b1_n) |-> (b1_dout == a_din));

  assert_b2_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (ab_le2 && !oe_b2_n) |-> (b2_dout == a_din));

  assert_b1_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ab_le1 && $past(!ab_le1) && !oe_b1_n && $past(!oe_b1_n)) |-> $stable(b1_dout));

  assert_b2_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ab_le2 && $past(!ab_le2) && !oe_b2_n && $past(!oe_b2_n)) |-> $stable(b2_dout));

  assert_a_bank1_R5: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && a_src_bank1 && ba_le1) |-> (a_dout == b1_din));

  assert_a_bank2_R5: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && !a_src_bank1 && ba_le2) |-> (a_dout == b2_din));

  assert_a_off_R6: assert property (@(posedge clk) disable iff (rst)
    oe_a_n |-> (!a_oe && a_dout == '0));

  assert_b_off_R6: assert property (@(posedge clk) disable iff (rst)
    (oe_b1_n |-> (!b1_oe && b1_dout == '0)) and (oe_b2_n |-> (!b2_oe && b2_dout == '0)));
endmodule

bind mux_latch_exchanger xchg_checker #(.W(W)) u_chk (.*);

// File: tb/test_mux_latch_exchanger.sv
module test_mux_latch_exchanger;
  localparam int W = 12;
  localparam int NV = 12;

  typedef struct packed {
    logic [7:0]   ctl;  // ab_le1 ab_le2 ba_le1 ba_le2 oe_a_n oe_b1_n oe_b2_n a_src_bank1
    logic [W-1:0] a;
    logic [W-1:0] b1;
    logic [W-1:0] b2;
    logic [2:0]   eoe;  // a_oe b1_oe b2_oe
    logic [W-1:0] ea;
    logic [W-1:0] eb1;
    logic [W-1:0] eb2;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'b10001001, 12'h123, 12'h000, 12'h000, 3'b011, 12'h000, 12'h123, 12'h000}, // R2 bank1 open
    '{8'b01001001, 12'h456, 12'h000, 12'h000, 3'b011, 12'h000, 12'h123, 12'h456}, // R3 bank1 held
    '{8'b00001001, 12'h789, 12'h000, 12'h000, 3'b011, 12'h000, 12'h123, 12'h456}, // R3 both held
    '{8'b11001001, 12'hABC, 12'h000, 12'h000, 3'b011, 12'h000, 12'hABC, 12'hABC}, // R7 both open
    '{8'b00100111, 12'h000, 12'h111, 12'h222, 3'b100, 12'h111, 12'h000, 12'h000}, // R4 bank1 to A
    '{8'b00010110, 12'h000, 12'h333, 12'h444, 3'b100, 12'h444, 12'h000, 12'h000}, // R4 bank2 to A
    '{8'b00000111, 12'h000, 12'h555, 12'h666, 3'b100, 12'h111, 12'h000, 12'h000}, // R5 sel bank1 held
    '{8'b00000110, 12'h000, 12'h555, 12'h666, 3'b100, 12'h444, 12'h000, 12'h000}, // R5 sel bank2 held
    '{8'b00001110, 12'hFFF, 12'h777, 12'h888, 3'b000, 12'h000, 12'h000, 12'h000}, // R6 all off
    '{8'b00001010, 12'hFFF, 12'h000, 12'h000, 3'b010, 12'h000, 12'hABC, 12'h000}, // R6 bank1 only
    '{8'b00001100, 12'hFFF, 12'h000, 12'h000, 3'b001, 12'h000, 12'h000, 12'hABC}, // R6 bank2 only
    '{8'b00000001, 12'h000, 12'h000, 12'h000, 3'b111, 12'h111, 12'hABC, 12'hABC}  // R7 all on
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_din = '0, b1_din = '0, b2_din = '0;
  logic [W-1:0] a_dout, b1_dout, b2_dout;
  logic a_oe, b1_oe, b2_oe;
  logic ab_le1 = 0, ab_le2 = 0, ba_le1 = 0, ba_le2 = 0;
  logic oe_a_n = 1, oe_b1_n = 1, oe_b2_n = 1, a_src_bank1 = 0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mux_latch_exchanger #(.W(W)) i_mux_latch_exchanger (
    .clk(clk), .rst(rst),
    .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe),
    .b1_din(b1_din), .b1_dout(b1_dout), .b1_oe(b1_oe),
    .b2_din(b2_din), .b2_dout(b2_dout), .b2_oe(b2_oe),
    .ab_le1(ab_le1), .ab_le2(ab_le2), .ba_le1(ba_le1), .ba_le2(ba_le2),
    .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
    .a_src_bank1(a_src_bank1)
  );

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";  1: return "R3";  2: return "R3";  3: return "R7";
      4: return "R4";  5: return "R4";  6: return "R5";  7: return "R5";
      8: return "R6";  9: return "R6";  10: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] c, logic [W-1:0] a, logic [W-1:0] b1, logic [W-1:0] b2);
    {ab_le1, ab_le2, ba_le1, ba_le2, oe_a_n, oe_b1_n, oe_b2_n, a_src_bank1} = c;
    a_din = a; b1_din = b1; b2_din = b2;
  endtask

  task automatic check_all(string tag, logic [2:0] eoe, logic [W-1:0] ea,
                           logic [W-1:0] eb1, logic [W-1:0] eb2);
    chk(tag, "oe", {9'b0, a_oe, b1_oe, b2_oe}, {9'b0, eoe});
    chk(tag, "a_dout", a_dout, ea);
    chk(tag, "b1_dout", b1_dout, eb1);
    chk(tag, "b2_dout", b2_dout, eb2);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with every enable active
    @(negedge clk);
    drive(8'b11110000, 12'h5A5, 12'h3C3, 12'h0F0);
    #2;
    check_all("R1", 3'b000, 12'h000, 12'h000, 12'h000);
    @(negedge clk);
    rst = 0;
    drive(8'b00001110, 12'h000, 12'h000, 12'h000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].ctl, VECS[i].a, VECS[i].b1, VECS[i].b2);
      #2;
      check_all(tag_of(i), VECS[i].eoe, VECS[i].ea, VECS[i].eb1, VECS[i].eb2);
    end

    // R3: close the bank-1 enable after one edge and check that it keeps that word
    @(negedge clk);
    drive(8'b10001001, 12'h2D2, 12'h000, 12'h000);
    @(negedge clk);
    drive(8'b00001001, 12'h0E0, 12'h000, 12'h000);
    #2;
    check_all("R3", 3'b011, 12'h000, 12'h2D2, 12'hABC);

    // R1: reset while the latches hold data, then read back zero
    @(negedge clk);
    rst = 1;
    drive(8'b00000001, 12'h000, 12'h000, 12'h000);
    #2;
    check_all("R1", 3'b000, 12'h000, 12'h000, 12'h000);
    @(negedge clk);
    rst = 0;
    #2;
    check_all("R1", 3'b111, 12'h000, 12'h000, 12'h000);
    drive(8'b00000000, 12'h000, 12'h000, 12'h000);
    #1;
    chk("R1", "a_dout bank2", a_dout, 12'h000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule